// File: doc/BRIEF.md
# Registered Command Bus with Parity Check

This block is a single register stage placed between a memory controller and one rank of DRAM devices. On every rising clock edge it captures the chip select, clock enable, termination enable, bank address, address and the three command strobes, and drives the registered copies to the DRAMs. Only the low fourteen address bits and all three bank bits continue to the DRAMs. The top two address bits arrive only so that the parity check can include them.

Alongside each command the controller sends one even-parity bit. The block checks this bit against the registered copy of the covered signals. When a selected command fails the check, the block pulls an active-low error flag low for one cycle. The flag is modelled as an open-drain pin, so it is either pulled low or released high.

A system that does not use parity can tie the parity input to any value and ignore the flag. Forwarding works the same either way. The whole block runs from one clock and uses a synchronous active-high reset.

Top module: `rcd_cmd_register`

## Requirements
- R1: While reset is high, each clock edge sets the outputs to their idle values: clock enable 0, chip select 1, all three strobes 1, termination enable 0, bank and address 0, and the error flag released (1).
- R2: Every clock edge copies chip select, clock enable, termination enable, bank bits [2:0], address bits [13:0] and the three strobes from the inputs to the outputs, so each output follows its input one edge later.
- R3: The check covers address bits [15:0], bank bits [1:0], the row strobe, the column strobe, the write strobe and the parity input. A command is clean when the XOR of all these bits is 0.
- R4: If a command is captured with chip select low and fails the check, the error flag goes to 0 one edge after its forwarded copy appears, which is the second edge after the command was driven.
- R5: Address bits [15:14] are not forwarded, but flipping either one alone makes a clean command fail the check.
- R6: Bank bit 2, chip select, clock enable and termination enable are not covered by the check. Flipping bank bit 2, clock enable or termination enable on a clean selected command leaves the error flag released.
- R7: A command captured with chip select high never pulls the error flag low, whatever its parity.
- R8: Each failing command pulls the flag low for exactly one cycle. Two failing commands in a row keep it low for two cycles, and a clean command that follows releases it.
- R9: The parity input does not affect forwarding. A failing command reaches the outputs exactly as a clean one would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all capture happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select from the controller, active low |
| cke_i | input | 1 | Clock enable from the controller |
| odt_i | input | 1 | Termination enable from the controller |
| ba_i | input | 3 | Bank address from the controller |
| addr_i | input | 16 | Address from the controller; bits [15:14] are used only by the check |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| par_i | input | 1 | Even-parity bit for the covered signals |
| cs_n_o | output | 1 | Registered chip select to the DRAMs |
| cke_o | output | 1 | Registered clock enable |
| odt_o | output | 1 | Registered termination enable |
| ba_o | output | 3 | Registered bank address |
| addr_o | output | 14 | Registered address bits [13:0] |
| ras_n_o | output | 1 | Registered row strobe |
| cas_n_o | output | 1 | Registered column strobe |
| we_n_o | output | 1 | Registered write strobe |
| err_out_n | output | 1 | Parity error flag: 0 means pulled low, 1 means released |

## Verification
The bench builds the block with its default widths: a 16-bit incoming address of which 14 bits are forwarded, 3 bank bits of which 2 are covered by the check, and one chip select. With these widths the bench can reach the bits that behave differently. These are the two address bits that feed only the check, bank bit 2, which is forwarded but not covered, and the uncovered control lines. It can also reach the chip-select gate on the flag and back-to-back failures, where a wrong pipeline depth would move or stretch the error pulse.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

    localparam int ADDR_IN_W  = 16;
    localparam int ADDR_OUT_W = 14;
    localparam int BANK_W     = 3;
    localparam int BANK_PAR_W = 2;

    typedef struct packed {
        logic                  cs_n;
        logic                  cke;
        logic                  odt;
        logic [BANK_W-1:0]     ba;
        logic [ADDR_IN_W-1:0]  addr;
        logic                  ras_n;
        logic                  cas_n;
        logic                  we_n;
    } cmd_word_t;

    localparam cmd_word_t CMD_IDLE = '{
        cs_n:  1'b1,
        cke:   1'b0,
        odt:   1'b0,
        ba:    '0,
        addr:  '0,
        ras_n: 1'b1,
        cas_n: 1'b1,
        we_n:  1'b1
    };

    // XOR across every bit covered by the check, parity bit included.
    function automatic logic covered_xor(
        input logic [ADDR_IN_W-1:0]  a,
        input logic [BANK_PAR_W-1:0] b,
        input logic                  ras_n,
        input logic                  cas_n,
        input logic                  we_n,
        input logic                  par
    );
        return (^a) ^ (^b) ^ ras_n ^ cas_n ^ we_n ^ par;
    endfunction

endpackage

// File: rtl/rcd_capture_stage.sv
module rcd_capture_stage
    import rcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cmd_word_t cmd_d,
    input  logic      par_d,
    output cmd_word_t cmd_q,
    output logic      par_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= CMD_IDLE;
            par_q <= 1'b0;
        end else begin
            cmd_q <= cmd_d;
            par_q <= par_d;
        end
    end

endmodule

// File: rtl/rcd_parity_check.sv
module rcd_parity_check
    import rcd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n_q,
    input  logic [ADDR_IN_W-1:0]  addr_q,
    input  logic [BANK_PAR_W-1:0] ba_q,
    input  logic                  ras_n_q,
    input  logic                  cas_n_q,
    input  logic                  we_n_q,
    input  logic                  par_q,
    output logic                  err_n
);

    logic mismatch;
    logic err_flag_q;

    always_comb begin
        mismatch = covered_xor(addr_q, ba_q, ras_n_q, cas_n_q, we_n_q, par_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag_q <= 1'b0;
        end else begin
            err_flag_q <= mismatch && !cs_n_q;
        end
    end

    assign err_n = !err_flag_q;

    // R7: the flag is only pulled low for a command whose registered select was active
    assert_err_needs_select_R7: assert property (@(posedge clk) disable iff (rst)
        !err_n |-> $past(!cs_n_q));

endmodule

// File: rtl/rcd_cmd_register.sv
module rcd_cmd_register
    import rcd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n_i,
    input  logic                  cke_i,
    input  logic                  odt_i,
    input  logic [BANK_W-1:0]     ba_i,
    input  logic [ADDR_IN_W-1:0]  addr_i,
    input  logic                  ras_n_i,
    input  logic                  cas_n_i,
    input  logic                  we_n_i,
    input  logic                  par_i,
    output logic                  cs_n_o,
    output logic                  cke_o,
    output logic                  odt_o,
    output logic [BANK_W-1:0]     ba_o,
    output logic [ADDR_OUT_W-1:0] addr_o,
    output logic                  ras_n_o,
    output logic                  cas_n_o,
    output logic                  we_n_o,
    output logic                  err_out_n
);

    cmd_word_t cmd_in;
    cmd_word_t cmd_reg;
    logic      par_reg;

    always_comb begin
        cmd_in.cs_n  = cs_n_i;
        cmd_in.cke   = cke_i;
        cmd_in.odt   = odt_i;
        cmd_in.ba    = ba_i;
        cmd_in.addr  = addr_i;
        cmd_in.ras_n = ras_n_i;
        cmd_in.cas_n = cas_n_i;
        cmd_in.we_n  = we_n_i;
    end

    rcd_capture_stage u_capture (
        .clk   (clk),
        .rst   (rst),
        .cmd_d (cmd_in),
        .par_d (par_i),
        .cmd_q (cmd_reg),
        .par_q (par_reg)
    );

    rcd_parity_check u_check (
        .clk     (clk),
        .rst     (rst),
        .cs_n_q  (cmd_reg.cs_n),
        .addr_q  (cmd_reg.addr),
        .ba_q    (cmd_reg.ba[BANK_PAR_W-1:0]),
        .ras_n_q (cmd_reg.ras_n),
        .cas_n_q (cmd_reg.cas_n),
        .we_n_q  (cmd_reg.we_n),
        .par_q   (par_reg),
        .err_n   (err_out_n)
    );

    assign cs_n_o  = cmd_reg.cs_n;
    assign cke_o   = cmd_reg.cke;
    assign odt_o   = cmd_reg.odt;
    assign ba_o    = cmd_reg.ba;
    assign addr_o  = cmd_reg.addr[ADDR_OUT_W-1:0];
    assign ras_n_o = cmd_reg.ras_n;
    assign cas_n_o = cmd_reg.cas_n;
    assign we_n_o  = cmd_reg.we_n;

    // Checking support: reset seen on the previous edge, and failure seen at the inputs.
    logic rst_seen_q;
    logic bad_in;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    always_comb begin
        bad_in = !cs_n_i &&
                 covered_xor(addr_i, ba_i[BANK_PAR_W-1:0], ras_n_i, cas_n_i, we_n_i, par_i);
    end

    // R1: one edge with reset high leaves every output idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst_seen_q |-> (!cke_o && cs_n_o && ras_n_o && cas_n_o && we_n_o &&
                        !odt_o && err_out_n));

    // R2: every forwarded line follows its input one edge later
    assert_forward_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cs_n_o == $past(cs_n_i) && cke_o == $past(cke_i) &&
                  odt_o == $past(odt_i) && ba_o == $past(ba_i) &&
                  addr_o == $past(addr_i[ADDR_OUT_W-1:0]) &&
                  ras_n_o == $past(ras_n_i) && cas_n_o == $past(cas_n_i) &&
                  we_n_o == $past(we_n_i)));

    // R4: a selected failing command pulls the flag low two edges after it is driven
    assert_error_timing_R4: assert property (@(posedge clk) disable iff (rst)
        bad_in |=> ##1 !err_out_n);

    // R8: a clean or deselected command leaves the flag released two edges later
    assert_error_release_R8: assert property (@(posedge clk) disable iff (rst)
        !bad_in |=> ##1 err_out_n);

endmodule

// File: tb/tb_rcd_cmd_register.sv
module tb_rcd_cmd_register;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        cs_n_i, cke_i, odt_i;
    logic [2:0]  ba_i;
    logic [15:0] addr_i;
    logic        ras_n_i, cas_n_i, we_n_i, par_i;
    logic        cs_n_o, cke_o, odt_o;
    logic [2:0]  ba_o;
    logic [13:0] addr_o;
    logic        ras_n_o, cas_n_o, we_n_o, err_out_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcd_cmd_register dut (
        .clk(clk), .rst(rst),
        .cs_n_i(cs_n_i), .cke_i(cke_i), .odt_i(odt_i), .ba_i(ba_i), .addr_i(addr_i),
        .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i), .par_i(par_i),
        .cs_n_o(cs_n_o), .cke_o(cke_o), .odt_o(odt_o), .ba_o(ba_o), .addr_o(addr_o),
        .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .err_out_n(err_out_n)
    );

    function automatic logic even_par(input logic [15:0] a, input logic [2:0] b,
                                      input logic r, input logic c, input logic w);
        return (^a) ^ b[0] ^ b[1] ^ r ^ c ^ w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic cs, input logic ck, input logic od, input logic [2:0] b,
                         input logic [15:0] a, input logic r, input logic c, input logic w,
                         input logic p);
        cs_n_i = cs; cke_i = ck; odt_i = od; ba_i = b; addr_i = a;
        ras_n_i = r; cas_n_i = c; we_n_i = w; par_i = p;
    endtask

    task automatic drive_idle();
        drive(1'b1, 1'b1, 1'b0, 3'd0, 16'd0, 1'b1, 1'b1, 1'b1, 1'b0);
    endtask

    // Drive one command, check its forwarded copy and then the flag it produces.
    task automatic one_cmd(input string req, input logic cs, input logic ck, input logic od,
                           input logic [2:0] b, input logic [15:0] a, input logic r,
                           input logic c, input logic w, input logic p, input logic exp_err_n);
        @(negedge clk);
        drive(cs, ck, od, b, a, r, c, w, p);
        @(negedge clk);
        check({req, " fwd"}, {cs_n_o, cke_o, odt_o, ba_o, addr_o, ras_n_o, cas_n_o, we_n_o},
              {cs, ck, od, b, a[13:0], r, c, w});
        drive_idle();
        @(negedge clk);
        check({req, " err"}, {31'd0, err_out_n}, {31'd0, exp_err_n});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        drive(1'b0, 1'b1, 1'b1, 3'd7, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        check("R1", {cs_n_o, cke_o, odt_o, ba_o, addr_o, ras_n_o, cas_n_o, we_n_o, err_out_n},
              {1'b1, 1'b0, 1'b0, 3'd0, 14'd0, 1'b1, 1'b1, 1'b1, 1'b1});
        drive_idle();
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_forward_clean();
        logic [15:0] a;
        a = 16'h1A5C;
        one_cmd("R2 activate", 1'b0, 1'b1, 1'b0, 3'd5, a, 1'b0, 1'b1, 1'b1,
                even_par(a, 3'd5, 1'b0, 1'b1, 1'b1), 1'b1);
        a = 16'h2F0F;
        one_cmd("R2 write", 1'b0, 1'b1, 1'b1, 3'd2, a, 1'b1, 1'b0, 1'b0,
                even_par(a, 3'd2, 1'b1, 1'b0, 1'b0), 1'b1);
        a = 16'h0000;
        one_cmd("R3 zeros", 1'b0, 1'b0, 1'b0, 3'd0, a, 1'b0, 1'b0, 1'b0,
                even_par(a, 3'd0, 1'b0, 1'b0, 1'b0), 1'b1);
    endtask

    task automatic t_parity_bad();
        logic [15:0] a;
        a = 16'h3333;
        one_cmd("R4 bad parity", 1'b0, 1'b1, 1'b0, 3'd1, a, 1'b1, 1'b0, 1'b1,
                ~even_par(a, 3'd1, 1'b1, 1'b0, 1'b1), 1'b0);
        // R9: the same failing command forwarded unchanged
        one_cmd("R9 fwd despite error", 1'b0, 1'b1, 1'b1, 3'd6, 16'h0ACE, 1'b0, 1'b1, 1'b0,
                ~even_par(16'h0ACE, 3'd6, 1'b0, 1'b1, 1'b0), 1'b0);
    endtask

    task automatic t_high_addr();
        logic [15:0] a;
        a = 16'h0123;
        one_cmd("R5 A15 flip", 1'b0, 1'b1, 1'b0, 3'd3, a ^ 16'h8000, 1'b1, 1'b1, 1'b0,
                even_par(a, 3'd3, 1'b1, 1'b1, 1'b0), 1'b0);
        one_cmd("R5 A14 flip", 1'b0, 1'b1, 1'b0, 3'd3, a ^ 16'h4000, 1'b1, 1'b1, 1'b0,
                even_par(a, 3'd3, 1'b1, 1'b1, 1'b0), 1'b0);
    endtask

    task automatic t_uncovered();
        logic [15:0] a;
        logic        p;
        a = 16'h0F0F;
        p = even_par(a, 3'd1, 1'b0, 1'b1, 1'b0);
        one_cmd("R6 BA2 flip", 1'b0, 1'b1, 1'b0, 3'd5, a, 1'b0, 1'b1, 1'b0, p, 1'b1);
        one_cmd("R6 CKE flip", 1'b0, 1'b0, 1'b0, 3'd1, a, 1'b0, 1'b1, 1'b0, p, 1'b1);
        one_cmd("R6 ODT flip", 1'b0, 1'b1, 1'b1, 3'd1, a, 1'b0, 1'b1, 1'b0, p, 1'b1);
    endtask

    task automatic t_deselect();
        logic [15:0] a;
        a = 16'h7777;
        one_cmd("R7 deselected bad", 1'b1, 1'b1, 1'b0, 3'd2, a, 1'b0, 1'b0, 1'b1,
                ~even_par(a, 3'd2, 1'b0, 1'b0, 1'b1), 1'b1);
    endtask

    task automatic t_back_to_back();
        logic [15:0] a;
        a = 16'h1111;
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b0, 3'd0, a, 1'b1, 1'b1, 1'b1, ~even_par(a, 3'd0, 1'b1, 1'b1, 1'b1));
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b0, 3'd1, a, 1'b1, 1'b1, 1'b1, ~even_par(a, 3'd1, 1'b1, 1'b1, 1'b1));
        @(negedge clk);
        check("R8 first pulse", {31'd0, err_out_n}, 32'd0);
        drive(1'b0, 1'b1, 1'b0, 3'd2, a, 1'b1, 1'b1, 1'b1, even_par(a, 3'd2, 1'b1, 1'b1, 1'b1));
        @(negedge clk);
        check("R8 second pulse", {31'd0, err_out_n}, 32'd0);
        drive_idle();
        @(negedge clk);
        check("R8 release after clean", {31'd0, err_out_n}, 32'd1);
        @(negedge clk);
        check("R8 stays released", {31'd0, err_out_n}, 32'd1);
    endtask

    initial begin
        drive_idle();
        t_reset();
        t_forward_clean();
        t_parity_bad();
        t_high_addr();
        t_uncovered();
        t_deselect();
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule